// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Unit

This block is the multiplier of a 16-bit microcontroller core. The core presents a 16-bit word pair: AX, made up of A (high byte) and X (low byte), and BC. It selects one of five operations and pulses `start`. The unit does one of three things: multiplies the two bytes of AX, multiplies AX by BC to a 32-bit product split across the two result words, or adds that 16×16 product into a 32-bit accumulator that it holds internally. Each operation has a fixed latency. Results and flag updates appear together with a single-cycle `done` pulse.

The accumulate forms produce two flags for the core's status word. On the signed form the carry flag reports a sign change of the accumulator and the auxiliary flag copies its new sign. On the unsigned form the carry flag reports a wrap past 2^32 and the auxiliary flag is cleared. The plain multiplies leave both flags and the accumulator alone. A host port can load the 32-bit accumulator while the unit is idle, and the port can always read it.

Top module: `mul_mac_unit`

## Requirements
- R1: With `op`=0 the unit forms the unsigned product of `ax_in[15:8]` and `ax_in[7:0]`. It drives the 16-bit product on `ax_out` and drives the `bc_in` value captured at start on `bc_out`.
- R2: With `op`=1 the unit forms the unsigned 32-bit product of `ax_in` and `bc_in`. Bits 31:16 go to `bc_out` and bits 15:0 go to `ax_out`.
- R3: With `op`=2 both operands are treated as two's-complement values and the signed 32-bit product is split the same way as in R2.
- R4: With `op`=4 the signed product of `ax_in` and `bc_in` is added to the accumulator modulo 2^32. `cy_out` becomes 1 exactly when bit 31 of the accumulator changed, and `ac_out` becomes the new bit 31.
- R5: With `op`=3 the unsigned product is added to the accumulator modulo 2^32. `cy_out` becomes 1 exactly when the new accumulator is smaller than the old one, and `ac_out` becomes 0. Both accumulate forms return the captured `ax_in`/`bc_in` on `ax_out`/`bc_out`.
- R6: `done` is high for exactly one cycle. It rises L rising edges after the edge that accepts `start`: L=1 for op 0, L=2 for ops 1 and 2, L=3 for ops 3 and 4. `busy` is high from acceptance until the edge that raises `done`.
- R7: A `start` pulse while `busy` is high has no effect on the running operation or its results. A `start` with `op` 5, 6 or 7 is not accepted.
- R8: Ops 0, 1 and 2 leave `acc_out`, `cy_out` and `ac_out` unchanged.
- R9: After a synchronous active-low reset, `acc_out`, `ax_out`, `bc_out`, `cy_out`, `ac_out`, `busy` and `done` are all 0.
- R10: `host_wr` loads `host_wdata` into the accumulator at the next edge when `busy` is low and is ignored while `busy` is high. A write in the same cycle as an accepted start is taken, and the accumulate then adds onto the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation |
| op | input | 3 | Operation select (0..4) |
| ax_in | input | 16 | AX operand (A high byte, X low byte) |
| bc_in | input | 16 | BC operand |
| host_wr | input | 1 | Accumulator load strobe |
| host_wdata | input | 32 | Accumulator load value |
| ax_out | output | 16 | AX result |
| bc_out | output | 16 | BC result |
| acc_out | output | 32 | Accumulator contents |
| cy_out | output | 1 | Carry flag |
| ac_out | output | 1 | Auxiliary flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two accumulator updates can meet on one edge: a host load and the start of an accumulate. The bench also drives a host load into the final cycle of a running accumulate. The first case must let the load through and then accumulate onto the loaded value. The second must drop the load so that only the accumulate result remains. Each is judged at the ports by comparing `acc_out` and the flags after `done` against values worked out by hand.

// File: rtl/mulmac_pkg.sv
// Package: operation codes and helpers shared by the multiply unit.
// Assumes the op field is 3 bits wide; codes above 4 are invalid.
package mulmac_pkg;

    typedef enum logic [2:0] {
        OP_MUL8U  = 3'd0,
        OP_MUL16U = 3'd1,
        OP_MUL16S = 3'd2,
        OP_MACU   = 3'd3,
        OP_MACS   = 3'd4
    } mm_op_e;

    // True for an operation code the unit executes.
    function automatic logic op_valid(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    // True for the two accumulate operations.
    function automatic logic op_is_mac(input logic [2:0] code);
        return (code == OP_MACU) || (code == OP_MACS);
    endfunction

endpackage

// File: rtl/mm_ctrl.sv
// Module: sequencing for the multiply unit. Accepts a start with a valid
// op when idle, counts the fixed latency of that op and flags the
// completion edge. Assumes every latency is at least 1.
module mm_ctrl
    import mulmac_pkg::*;
#(
    parameter int LAT_BYTE = 1,
    parameter int LAT_WORD = 2,
    parameter int LAT_MAC  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op,
    output logic       accept,
    output logic       busy,
    output logic       finish,
    output mm_op_e     op_q
);
    localparam int MAXL0 = (LAT_BYTE > LAT_WORD) ? LAT_BYTE : LAT_WORD;
    localparam int MAXL  = (MAXL0 > LAT_MAC) ? MAXL0 : LAT_MAC;
    localparam int CW    = (MAXL > 1) ? $clog2(MAXL) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    assign accept = start && !busy && op_valid(op);
    assign finish = busy && (cnt == '0);

    // Remaining-edge count loaded on acceptance, chosen by operation class.
    always_comb begin
        if (op == OP_MUL8U)
            load_val = CW'(LAT_BYTE - 1);
        else if (op_is_mac(op))
            load_val = CW'(LAT_MAC - 1);
        else
            load_val = CW'(LAT_WORD - 1);
    end

    // Busy flag, latched op and latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            op_q <= OP_MUL8U;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= load_val;
            op_q <= mm_op_e'(op);
        end else if (finish) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> (busy && $stable(op_q)));

    // R7
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

endmodule

// File: rtl/mm_product.sv
// Module: combinational multiplier. Forms the byte product of the two
// halves of operand a, or the full signed/unsigned product of a and b.
// Assumes W is even.
module mm_product
    import mulmac_pkg::*;
#(
    parameter int W = 16
) (
    input  mm_op_e          op,
    input  logic [W-1:0]    a_op,
    input  logic [W-1:0]    b_op,
    output logic [2*W-1:0]  prod
);
    localparam int H  = W / 2;
    localparam int PW = 2 * W;

    logic [W-1:0]         byte_prod;
    logic [PW-1:0]        uns_prod;
    logic signed [PW-1:0] sgn_prod;

    // Three product forms computed side by side.
    always_comb begin
        byte_prod = {{H{1'b0}}, a_op[W-1:H]} * {{H{1'b0}}, a_op[H-1:0]};
        uns_prod  = {{W{1'b0}}, a_op} * {{W{1'b0}}, b_op};
        sgn_prod  = PW'($signed(a_op)) * PW'($signed(b_op));
    end

    // Select the form the operation needs.
    always_comb begin
        case (op)
            OP_MUL8U:           prod = {{W{1'b0}}, byte_prod};
            OP_MUL16S, OP_MACS: prod = sgn_prod;
            default:            prod = uns_prod;
        endcase
    end

endmodule

// File: rtl/mm_accum.sv
// Module: accumulator register with its two flags. Adds a product on a
// MAC completion and takes host loads only while the unit is idle.
// Assumes mac_en is never high while idle.
module mm_accum #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          host_wr,
    input  logic [AW-1:0] host_wdata,
    input  logic          mac_en,
    input  logic          mac_signed,
    input  logic [AW-1:0] prod,
    output logic [AW-1:0] acc,
    output logic          cy,
    output logic          ac
);
    logic [AW-1:0] sum;

    // Modulo-2^AW sum shared by both accumulate forms.
    assign sum = acc + prod;

    // Accumulator and flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cy  <= 1'b0;
            ac  <= 1'b0;
        end else if (mac_en) begin
            acc <= sum;
            if (mac_signed) begin
                cy <= sum[AW-1] ^ acc[AW-1];
                ac <= sum[AW-1];
            end else begin
                cy <= (sum < acc);
                ac <= 1'b0;
            end
        end else if (host_wr && idle) begin
            acc <= host_wdata;
        end
    end

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_en |=> $stable({cy, ac}));

    // R5
    unsigned_ac_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && !mac_signed) |=> !ac);

    // R10
    busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !mac_en) |=> $stable(acc));

endmodule

// File: rtl/mul_mac_unit.sv
// Module: top of the multiply / multiply-accumulate unit. Captures the
// operands at start, runs the fixed latency, then registers results,
// flags and a one-cycle done pulse. Assumes the core holds no other copy
// of the accumulator.
module mul_mac_unit
    import mulmac_pkg::*;
#(
    parameter int W        = 16,
    parameter int LAT_BYTE = 1,
    parameter int LAT_WORD = 2,
    parameter int LAT_MAC  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [W-1:0]    ax_in,
    input  logic [W-1:0]    bc_in,
    input  logic            host_wr,
    input  logic [2*W-1:0]  host_wdata,
    output logic [W-1:0]    ax_out,
    output logic [W-1:0]    bc_out,
    output logic [2*W-1:0]  acc_out,
    output logic            cy_out,
    output logic            ac_out,
    output logic            busy,
    output logic            done
);
    localparam int AW = 2 * W;

    logic          accept;
    logic          finish;
    mm_op_e        op_q;
    logic [W-1:0]  ax_q;
    logic [W-1:0]  bc_q;
    logic [AW-1:0] prod;
    logic          mac_en;

    mm_ctrl #(
        .LAT_BYTE(LAT_BYTE),
        .LAT_WORD(LAT_WORD),
        .LAT_MAC (LAT_MAC)
    ) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op    (op),
        .accept(accept),
        .busy  (busy),
        .finish(finish),
        .op_q  (op_q)
    );

    mm_product #(.W(W)) i_prod (
        .op  (op_q),
        .a_op(ax_q),
        .b_op(bc_q),
        .prod(prod)
    );

    assign mac_en = finish && op_is_mac(op_q);

    mm_accum #(.AW(AW)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (!busy),
        .host_wr   (host_wr),
        .host_wdata(host_wdata),
        .mac_en    (mac_en),
        .mac_signed(op_q == OP_MACS),
        .prod      (prod),
        .acc       (acc_out),
        .cy        (cy_out),
        .ac        (ac_out)
    );

    // Operand capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ax_q <= '0;
            bc_q <= '0;
        end else if (accept) begin
            ax_q <= ax_in;
            bc_q <= bc_in;
        end
    end

    // Result words and done pulse, written on the completion edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ax_out <= '0;
            bc_out <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                case (op_q)
                    OP_MUL8U: begin
                        ax_out <= prod[W-1:0];
                        bc_out <= bc_q;
                    end
                    OP_MUL16U, OP_MUL16S: begin
                        ax_out <= prod[W-1:0];
                        bc_out <= prod[AW-1:W];
                    end
                    default: begin
                        ax_out <= ax_q;
                        bc_out <= bc_q;
                    end
                endcase
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    results_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable({ax_out, bc_out}));

endmodule

// File: tb/test_mul_mac_unit.sv
module test_mul_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] ax_in = '0;
    logic [15:0] bc_in = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [15:0] ax_out;
    logic [15:0] bc_out;
    logic [31:0] acc_out;
    logic        cy_out;
    logic        ac_out;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat;
    int ndone;

    always #4 clk = ~clk;

    mul_mac_unit i_mul_mac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .ax_in(ax_in), .bc_in(bc_in), .host_wr(host_wr),
        .host_wdata(host_wdata), .ax_out(ax_out), .bc_out(bc_out),
        .acc_out(acc_out), .cy_out(cy_out), .ac_out(ac_out),
        .busy(busy), .done(done)
    );

    // op, ax, bc, exp ax, exp bc, exp acc, exp cy, exp ac
    localparam logic [100:0] VEC [13] = '{
        {3'd0, 16'h1234, 16'hBEEF, 16'h03A8, 16'hBEEF, 32'h00000000, 1'b0, 1'b0},
        {3'd0, 16'hFFFF, 16'h0000, 16'hFE01, 16'h0000, 32'h00000000, 1'b0, 1'b0},
        {3'd1, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 32'h00000000, 1'b0, 1'b0},
        {3'd2, 16'hFFFF, 16'h0002, 16'hFFFE, 16'hFFFF, 32'h00000000, 1'b0, 1'b0},
        {3'd2, 16'h8000, 16'h8000, 16'h0000, 16'h4000, 32'h00000000, 1'b0, 1'b0},
        {3'd1, 16'h1234, 16'h0010, 16'h2340, 16'h0001, 32'h00000000, 1'b0, 1'b0},
        {3'd3, 16'h1000, 16'h1000, 16'h1000, 16'h1000, 32'h01000000, 1'b0, 1'b0},
        {3'd4, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 32'h40FF0001, 1'b0, 1'b0},
        {3'd4, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, 32'h80FE0002, 1'b1, 1'b1},
        {3'd0, 16'h0203, 16'h1111, 16'h0006, 16'h1111, 32'h80FE0002, 1'b1, 1'b1},
        {3'd3, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'h80FC0003, 1'b1, 1'b0},
        {3'd4, 16'hFFFF, 16'h0003, 16'hFFFF, 16'h0003, 32'h80FC0000, 1'b0, 1'b1},
        {3'd3, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 32'h80FC0001, 1'b0, 1'b0}
    };

    function automatic int exp_lat(input logic [2:0] code);
        if (code == 3'd0) return 1;
        if (code == 3'd1 || code == 3'd2) return 2;
        return 3;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one start pulse, then count edges until done; returns edge count.
    task automatic run_op(input logic [2:0] code, input logic [15:0] a,
                          input logic [15:0] b, output int n);
        @(negedge clk);
        op = code; ax_in = a; bc_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 acc", acc_out, 32'h0);
        chk("R9 ax/bc", {ax_out, bc_out}, 32'h0);
        chk("R9 flags/busy/done", {28'h0, cy_out, ac_out, busy, done}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 13; i++) begin
            run_op(VEC[i][100:98], VEC[i][97:82], VEC[i][81:66], lat);
            chk("R6 latency", lat, exp_lat(VEC[i][100:98]));
            chk("R1/R2/R3 ax_out", {16'h0, ax_out}, {16'h0, VEC[i][65:50]});
            chk("R1/R2/R3 bc_out", {16'h0, bc_out}, {16'h0, VEC[i][49:34]});
            chk("R4/R5/R8 acc", acc_out, VEC[i][33:2]);
            chk("R4/R5/R8 flags", {30'h0, cy_out, ac_out}, {30'h0, VEC[i][1:0]});
            @(negedge clk);
            chk("R6 single pulse", {31'h0, done}, 32'h0);
        end

        // R10 idle host load, then signed overflow past bit 31 (R4)
        @(negedge clk);
        host_wr = 1'b1; host_wdata = 32'h7FFFFFFF;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R10 idle load", acc_out, 32'h7FFFFFFF);
        run_op(3'd4, 16'h0001, 16'h0001, lat);
        chk("R4 overflow acc", acc_out, 32'h80000000);
        chk("R4 overflow flags", {30'h0, cy_out, ac_out}, 32'h3);

        // R7 start while busy is ignored
        @(negedge clk);
        op = 3'd3; ax_in = 16'h0002; bc_in = 16'h0003; start = 1'b1;
        @(negedge clk);
        op = 3'd0; ax_in = 16'h0505; bc_in = 16'hAAAA;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        for (int k = 0; k < 6; k++) begin
            if (done) ndone++;
            @(negedge clk);
        end
        chk("R7 one done", ndone, 1);
        chk("R7 result of first op", {ax_out, bc_out}, {16'h0002, 16'h0003});
        chk("R7 acc", acc_out, 32'h80000006);

        // R7 invalid op code not accepted
        @(negedge clk);
        op = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 invalid not busy", {31'h0, busy}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R7 invalid no done", {31'h0, done}, 32'h0);
        chk("R7 invalid acc", acc_out, 32'h80000006);

        // R10 host load in the same cycle as an accepted start
        @(negedge clk);
        op = 3'd3; ax_in = 16'h0010; bc_in = 16'h0010; start = 1'b1;
        host_wr = 1'b1; host_wdata = 32'h00001000;
        @(negedge clk);
        start = 1'b0; host_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 load+start acc", acc_out, 32'h00001100);

        // R10 host load during the completion cycle of an accumulate is dropped
        @(negedge clk);
        op = 3'd3; ax_in = 16'h0001; bc_in = 16'h0002; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = 32'hDEADBEEF;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R10 busy load ignored", acc_out, 32'h00001102);

        // R9 synchronous reset clears state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset acc", acc_out, 32'h0);
        chk("R9 reset outs", {ax_out, bc_out}, 32'h0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule